// File: doc/BRIEF.md
# Fixed-Priority Stream Grant Arbiter

This block chooses one of eight DMA stream requests for a single master port. Each stream supplies a request bit, an enable bit and a two-bit software priority level. The block first picks the highest software level among the enabled, requesting streams. If several of those streams share that level, it picks the one with the lowest stream number. A system with two master ports uses one instance for each port.

The chosen stream receives a registered one-hot grant, together with its binary index and a valid flag. The grant holds until the access sequence signals its end with a one-cycle done pulse. The register edge that samples done clears the grant. The arbiter makes a fresh decision at the next edge, so a request that stays raised cannot keep the port across a done pulse without competing again. The block performs no bus transfers, and its ordering is fixed priority only.

Top module: `stream_prio_arb`

## Requirements
- R1: After reset, grant_o is all zero, grant_idx_o is zero and grant_valid_o is low.
- R2: Level encoding: 2'b11 very high, 2'b10 high, 2'b01 medium, 2'b00 low. Stream i's level sits at level_i[2*i+1:2*i]. When the arbiter is idle and at least one stream is eligible (req and enable both high), the edge that samples those inputs grants an eligible stream with the highest level.
- R3: When several eligible streams share the highest level, the arbiter grants the one with the lowest index. For example, stream 2 wins over stream 4.
- R4: A request from a stream whose enable_i bit is low is ignored. It never receives a grant, and it does not change which stream wins.
- R5: While grant_valid_o is high, grant_o has exactly one bit set, and that bit is the one selected by grant_idx_o.
- R6: While a grant is held and done_i is low, grant_o and grant_idx_o stay unchanged, whatever happens on req_i, enable_i and level_i.
- R7: A clock edge that samples done_i high during a grant clears grant_o and grant_valid_o. The next edge makes a new decision from the inputs present at that time.
- R8: When the arbiter is idle and no stream is eligible, grant_valid_o stays low and grant_o stays zero.
- R9: A done_i pulse while no grant is held has no effect. A request arriving in the same cycle is granted as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Per-stream request |
| enable_i | input | 8 | Per-stream enable; a low bit masks the request |
| level_i | input | 16 | Per-stream 2-bit software priority, packed by stream index |
| done_i | input | 1 | One-cycle end-of-access pulse from the granted stream |
| grant_o | output | 8 | One-hot grant, registered |
| grant_idx_o | output | 3 | Binary index of the granted stream |
| grant_valid_o | output | 1 | A grant is currently held |

## Verification
Every output is a register. A grant therefore appears one edge after the idle arbiter sees an eligible request, and it disappears one edge after done is sampled. A new grant follows one edge after that. The bench changes inputs on falling edges and reads outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. Over several hundred generated patterns of requests, enables and levels, the bench computes the expected winner by scanning levels from top to bottom and indices from bottom to top. It checks the hold property and the release-then-regrant sequence at those same one-edge offsets.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    LVL_LOW    = 2'b00,
    LVL_MEDIUM = 2'b01,
    LVL_HIGH   = 2'b10,
    LVL_VHIGH  = 2'b11
  } level_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_state_e;

  localparam int unsigned LEVEL_W = 2;

endpackage

// File: rtl/arb_req_qualify.sv
module arb_req_qualify #(
  parameter int unsigned NUM_STREAMS = 8
) (
  input  logic [NUM_STREAMS-1:0] req_i,
  input  logic [NUM_STREAMS-1:0] enable_i,
  output logic [NUM_STREAMS-1:0] eligible_o,
  output logic                   any_o
);

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_mask
    assign eligible_o[s] = req_i[s] & enable_i[s];
  end

  assign any_o = |eligible_o;

endmodule

// File: rtl/arb_level_select.sv
module arb_level_select
  import arb_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 8,
  localparam int unsigned IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_STREAMS-1:0]         eligible_i,
  input  logic [NUM_STREAMS*LEVEL_W-1:0] level_i,
  output logic                           win_valid_o,
  output logic [IDX_W-1:0]               win_idx_o,
  output logic [NUM_STREAMS-1:0]         win_onehot_o
);

  logic [LEVEL_W-1:0] best_lvl;
  logic [IDX_W-1:0]   best_idx;
  logic               found;

  // Scan from the top index down; ">=" lets lower indices overtake on ties.
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    found    = 1'b0;
    for (int s = NUM_STREAMS - 1; s >= 0; s--) begin
      if (eligible_i[s] && (!found || (level_i[s*LEVEL_W +: LEVEL_W] >= best_lvl))) begin
        best_lvl = level_i[s*LEVEL_W +: LEVEL_W];
        best_idx = IDX_W'(s);
        found    = 1'b1;
      end
    end
  end

  assign win_valid_o = found;
  assign win_idx_o   = best_idx;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_onehot
    assign win_onehot_o[s] = found && (best_idx == IDX_W'(s));
  end

  // R4: the chosen stream is one the qualifier marked eligible
  a_r4_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> eligible_i[win_idx_o]);

  // R8: a winner exists exactly when some stream is eligible
  a_r8_valid_iff_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o == (|eligible_i));

endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold
  import arb_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 8,
  localparam int unsigned IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   win_valid_i,
  input  logic [IDX_W-1:0]       win_idx_i,
  input  logic [NUM_STREAMS-1:0] win_onehot_i,
  input  logic                   done_i,
  output logic [NUM_STREAMS-1:0] grant_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic                   grant_valid_o
);

  arb_state_e             state_q, state_d;
  logic [NUM_STREAMS-1:0] grant_q, grant_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic                   load_en;

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    idx_d   = idx_q;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (win_valid_i) begin
          state_d = ST_BUSY;
          grant_d = win_onehot_i;
          idx_d   = win_idx_i;
          load_en = 1'b1;
        end
      end
      ST_BUSY: begin
        if (done_i) begin
          state_d = ST_IDLE;
          grant_d = '0;
          idx_d   = '0;
          load_en = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        grant_d = '0;
        idx_d   = '0;
        load_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
      idx_q   <= '0;
    end else if (load_en) begin
      state_q <= state_d;
      grant_q <= grant_d;
      idx_q   <= idx_d;
    end
  end

  assign grant_o       = grant_q;
  assign grant_idx_o   = idx_q;
  assign grant_valid_o = (state_q == ST_BUSY);

  // R5: exactly one grant bit, selected by the index
  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ($countones(grant_o) == 1) && grant_o[grant_idx_o]);

  // R6: grant held until done
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !done_i) |=> grant_valid_o && $stable(grant_o) && $stable(grant_idx_o));

  // R7: done releases the grant at the next edge
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && done_i) |=> !grant_valid_o && (grant_o == '0));

  // R8: no stray grant bits while idle
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o |-> (grant_o == '0));

endmodule

// File: rtl/stream_prio_arb.sv
module stream_prio_arb
  import arb_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 8,
  localparam int unsigned IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_STREAMS-1:0]         req_i,
  input  logic [NUM_STREAMS-1:0]         enable_i,
  input  logic [NUM_STREAMS*LEVEL_W-1:0] level_i,
  input  logic                           done_i,
  output logic [NUM_STREAMS-1:0]         grant_o,
  output logic [IDX_W-1:0]               grant_idx_o,
  output logic                           grant_valid_o
);

  logic [NUM_STREAMS-1:0] elig_w;
  logic                   any_w;
  logic                   win_valid_w;
  logic [IDX_W-1:0]       win_idx_w;
  logic [NUM_STREAMS-1:0] win_onehot_w;

  arb_req_qualify #(.NUM_STREAMS(NUM_STREAMS)) u_qualify (
    .req_i      (req_i),
    .enable_i   (enable_i),
    .eligible_o (elig_w),
    .any_o      (any_w)
  );

  arb_level_select #(.NUM_STREAMS(NUM_STREAMS)) u_select (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .eligible_i   (elig_w),
    .level_i      (level_i),
    .win_valid_o  (win_valid_w),
    .win_idx_o    (win_idx_w),
    .win_onehot_o (win_onehot_w)
  );

  arb_grant_hold #(.NUM_STREAMS(NUM_STREAMS)) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .win_valid_i   (win_valid_w),
    .win_idx_i     (win_idx_w),
    .win_onehot_i  (win_onehot_w),
    .done_i        (done_i),
    .grant_o       (grant_o),
    .grant_idx_o   (grant_idx_o),
    .grant_valid_o (grant_valid_o)
  );

  // R4: a fresh grant goes only to a stream that was requesting and enabled
  a_r4_grant_was_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> ((($past(req_i & enable_i)) >> grant_idx_o) & 1) != 0);

  // R8: an idle arbiter with eligible requests must grant next edge
  a_r8_grant_when_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_valid_o && any_w) |=> grant_valid_o);

endmodule

// File: tb/stream_prio_arb_tb.sv
module stream_prio_arb_tb_top;

  localparam int N     = 8;
  localparam int IDX_W = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [N-1:0]   req_i;
  logic [N-1:0]   enable_i;
  logic [2*N-1:0] level_i;
  logic           done_i;
  logic [N-1:0]   grant_o;
  logic [IDX_W-1:0] grant_idx_o;
  logic           grant_valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit timed_out = 1'b0;
  logic [31:0] seed = 32'h1F2E_3D4C;

  always #4 clk_i = ~clk_i;  // 125 MHz

  stream_prio_arb #(.NUM_STREAMS(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .enable_i(enable_i),
    .level_i(level_i), .done_i(done_i), .grant_o(grant_o),
    .grant_idx_o(grant_idx_o), .grant_valid_o(grant_valid_o)
  );

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Expected winner: scan levels from very high down, indices from 0 up.
  task automatic model(input logic [N-1:0] rq, input logic [N-1:0] en,
                       input logic [2*N-1:0] lv, output bit v, output int idx);
    v = 1'b0; idx = 0;
    for (int l = 3; l >= 0 && !v; l--) begin
      for (int s = 0; s < N && !v; s++) begin
        if (rq[s] && en[s] && (int'(lv[2*s +: 2]) == l)) begin
          v = 1'b1; idx = s;
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_grant(input string tag, input bit ev, input int ei);
    logic [N-1:0] ev_vec;
    ev_vec = ev ? (N'(1) << ei) : '0;
    chk({tag, " valid"}, 32'(grant_valid_o), 32'(ev));
    chk({tag, " vector"}, 32'(grant_o), 32'(ev_vec));
    chk({tag, " index"}, 32'(grant_idx_o), ev ? 32'(ei) : 32'd0);
  endtask

  // One full scenario: grant, hold under changed inputs, release, regrant, release.
  task automatic scenario(input string tag, input logic [N-1:0] rq,
                          input logic [N-1:0] en, input logic [2*N-1:0] lv);
    bit ev; int ei; bit ev2; int ei2;
    logic [N-1:0] rq2; logic [N-1:0] en2; logic [2*N-1:0] lv2;
    req_i = rq; enable_i = en; level_i = lv; done_i = 1'b0;
    model(rq, en, lv, ev, ei);
    @(negedge clk_i);
    chk_grant(tag, ev, ei);
    if (ev) begin
      rq2 = N'(next_rand()); en2 = N'(next_rand()) | N'(8'h81); lv2 = (2*N)'(next_rand());
      req_i = rq2; enable_i = en2; level_i = lv2;
      @(negedge clk_i);
      chk_grant("R6 hold", ev, ei);
      @(negedge clk_i);
      chk_grant("R6 hold", ev, ei);
      done_i = 1'b1;
      @(negedge clk_i);
      done_i = 1'b0;
      chk_grant("R7 release", 1'b0, 0);
      model(rq2, en2, lv2, ev2, ei2);
      @(negedge clk_i);
      chk_grant("R7 regrant", ev2, ei2);
      if (ev2) begin
        done_i = 1'b1;
        @(negedge clk_i);
        done_i = 1'b0;
      end
    end
    req_i = '0;
    @(negedge clk_i);
  endtask

  function automatic logic [2*N-1:0] all_level(input logic [1:0] l);
    logic [2*N-1:0] r;
    for (int s = 0; s < N; s++) r[2*s +: 2] = l;
    return r;
  endfunction

  task automatic run_all();
    logic [2*N-1:0] lv;
    req_i = '0; enable_i = '0; level_i = '0; done_i = 1'b0; rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk_grant("R1 reset", 1'b0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_grant("R1 after release", 1'b0, 0);

    // R3: stream 2 beats stream 4 at equal level
    scenario("R3 tie 2v4", 8'b0001_0100, 8'hFF, all_level(2'b10));
    // R3: all streams tie at each level
    for (int l = 0; l < 4; l++) scenario("R3 all tie", 8'hFF, 8'hFF, all_level(2'(l)));
    // R2: single higher stream at top index
    lv = all_level(2'b00); lv[15:14] = 2'b11;
    scenario("R2 top wins", 8'hFF, 8'hFF, lv);
    // R4: highest stream disabled does not win
    scenario("R4 masked", 8'hFF, 8'h7F, lv);
    // R8: requests present but all disabled
    scenario("R8 none", 8'hFF, 8'h00, lv);
    scenario("R8 no req", 8'h00, 8'hFF, lv);
    // R2: each single stream at each level alone
    for (int s = 0; s < N; s++)
      scenario("R2 single", N'(1) << s, 8'hFF, all_level(2'(s)));

    // R9: done while idle, same cycle as a new request
    req_i = 8'b0010_0000; enable_i = 8'hFF; level_i = all_level(2'b01); done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
    chk_grant("R9 done idle", 1'b1, 5);
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0; req_i = '0;
    @(negedge clk_i);

    // R2 R3 R4: generated sweep
    for (int k = 0; k < 400; k++)
      scenario("R2 sweep", N'(next_rand()), N'(next_rand()), (2*N)'(next_rand()));
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule